// File: doc/BRIEF.md
# Inter-Processor Doorbell Signal Controller

This block is a memory-mapped doorbell controller through which processors raise numbered signals toward one another. A signal is named by a 32-bit identifier that packs a client number into the upper half-word and a signal number into the lower half-word. The controller keeps a fixed table of slots, `NUM_CLIENTS` by `NUM_SIGNALS`. Every slot holds one pending bit and one enable bit.

Software raises a signal by writing its identifier to the raise register. On the receiving side, software arms or disarms individual signals. It finds outstanding work by reading the receive register, which reports one pending, armed signal per read, and acknowledges that signal by writing the same identifier to the acknowledge register. Software repeats this until the receive register returns all ones. A registered level interrupt stays high while any armed signal is pending.

Reads return their data one cycle after the read strobe. A single write port carries all register writes, so only one table update happens per cycle.

Top module: `ipsig_ctrl`

## Requirements
- R1: After reset, every pending and enable bit is zero, `irq_o` is low, `rdata` is zero, and a read of the receive register (offset 0x10) returns 0xFFFFFFFF.
- R2: An identifier carries the client number in bits 31:16 and the signal number in bits 15:0. It selects slot `client*NUM_SIGNALS + signal`, and a receive read returns the identifier packed the same way.
- R3: A write to offset 0x0C sets the pending bit of the named slot. A slot that is pending but not enabled is reported neither by receive reads nor on `irq_o`.
- R4: A write to offset 0x14 enables the named slot, and a write to offset 0x18 disables it. Both leave every other slot's enable bit and all pending bits unchanged.
- R5: The value of a read strobe on offset 0x10 appears on `rdata` one cycle later. It is the identifier of the lowest-index slot that is both pending and enabled, or 0xFFFFFFFF when there is none. `rdata` holds its value while no read is strobed.
- R6: A write to offset 0x1C clears the pending bit of the named slot. Repeated read-then-acknowledge therefore returns each pending, enabled signal exactly once and then 0xFFFFFFFF.
- R7: An identifier whose client number is at least `NUM_CLIENTS`, or whose signal number is at least `NUM_SIGNALS`, changes no state on any write and is never returned by a read.
- R8: `irq_o` is high exactly one cycle after a cycle in which at least one slot is both pending and enabled.
- R9: A read strobe on any offset other than 0x10 returns zero.
- R10: A pending bit survives while its slot is disabled. The signal becomes visible to reads and to `irq_o` again once the slot is re-enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | 32 | Write data (packed signal identifier) |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_o | output | 1 | Level interrupt: an enabled signal is pending |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, since the relations between read data and the interrupt level are stated only for cycles without a concurrent table update. The stimulus applies one access at a time, separated by idle cycles, and never overlaps a read with a write. Inputs change only on the falling clock edge. Identifiers outside the table are driven on purpose, covering both the client and the signal half-words and stray upper bits, to exercise the ignore rule.

// File: rtl/ipsig_pkg.sv
package ipsig_pkg;

    // Register byte offsets
    localparam int OFF_RAISE   = 'h0C;
    localparam int OFF_RECV    = 'h10;
    localparam int OFF_ARM     = 'h14;
    localparam int OFF_DISARM  = 'h18;
    localparam int OFF_ACK     = 'h1C;

    // Identifier layout
    localparam int ID_W        = 32;
    localparam int HALF_W      = 16;
    localparam logic [ID_W-1:0] RECV_EMPTY = '1;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RAISE,
        OP_ARM,
        OP_DISARM,
        OP_ACK
    } wr_op_e;

endpackage

// File: rtl/ipsig_op_decode.sv
module ipsig_op_decode
    import ipsig_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_op_e            op
);

    always_comb begin
        op = OP_NONE;
        if (wr_en) begin
            if (addr == ADDR_W'(OFF_RAISE))       op = OP_RAISE;
            else if (addr == ADDR_W'(OFF_ARM))    op = OP_ARM;
            else if (addr == ADDR_W'(OFF_DISARM)) op = OP_DISARM;
            else if (addr == ADDR_W'(OFF_ACK))    op = OP_ACK;
        end
    end

endmodule

// File: rtl/ipsig_id_decode.sv
module ipsig_id_decode
    import ipsig_pkg::*;
#(
    parameter int NUM_CLIENTS = 8,
    parameter int NUM_SIGNALS = 4,
    localparam int NUM_SLOTS  = NUM_CLIENTS * NUM_SIGNALS
) (
    input  logic [ID_W-1:0]      id,
    output logic [NUM_SLOTS-1:0] slot_hit
);

    logic [HALF_W-1:0] client_num;
    logic [HALF_W-1:0] signal_num;

    assign client_num = id[ID_W-1:HALF_W];
    assign signal_num = id[HALF_W-1:0];

    // One comparator pair per slot; an out-of-table identifier hits nothing.
    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
        for (genvar s = 0; s < NUM_SIGNALS; s++) begin : g_signal
            assign slot_hit[c*NUM_SIGNALS + s] =
                (client_num == HALF_W'(c)) && (signal_num == HALF_W'(s));
        end
    end

endmodule

// File: rtl/ipsig_first_slot.sv
module ipsig_first_slot #(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    // Scan from the top down so the lowest set index is the last one kept.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ipsig_ctrl.sv
module ipsig_ctrl
    import ipsig_pkg::*;
#(
    parameter int NUM_CLIENTS = 8,
    parameter int NUM_SIGNALS = 4,
    parameter int ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_o
);

    localparam int NUM_SLOTS = NUM_CLIENTS * NUM_SIGNALS;
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] pend;
        logic [NUM_SLOTS-1:0] en;
        logic                 irq;
        logic [ID_W-1:0]      rdata;
    } state_t;

    state_t st_d, st_q;

    wr_op_e               wr_op;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic [NUM_SLOTS-1:0] live_vec;
    logic                 live_any;
    logic [IDX_W-1:0]     live_idx;
    logic [HALF_W-1:0]    rx_client;
    logic [HALF_W-1:0]    rx_signal;
    logic [NUM_SLOTS-1:0] pend_vec;
    logic [NUM_SLOTS-1:0] en_vec;

    ipsig_op_decode #(
        .ADDR_W (ADDR_W)
    ) u_op_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .op    (wr_op)
    );

    ipsig_id_decode #(
        .NUM_CLIENTS (NUM_CLIENTS),
        .NUM_SIGNALS (NUM_SIGNALS)
    ) u_id_dec (
        .id       (wdata),
        .slot_hit (slot_hit)
    );

    assign live_vec = st_q.pend & st_q.en;

    ipsig_first_slot #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_first (
        .req (live_vec),
        .any (live_any),
        .idx (live_idx)
    );

    // Slot index back to the packed client/signal identifier
    assign rx_client = HALF_W'(32'(live_idx) / NUM_SIGNALS);
    assign rx_signal = HALF_W'(32'(live_idx) % NUM_SIGNALS);

    always_comb begin
        st_d = st_q;

        unique case (wr_op)
            OP_RAISE:  st_d.pend = st_q.pend | slot_hit;
            OP_ACK:    st_d.pend = st_q.pend & ~slot_hit;
            OP_ARM:    st_d.en   = st_q.en | slot_hit;
            OP_DISARM: st_d.en   = st_q.en & ~slot_hit;
            default:   ;
        endcase

        st_d.irq = |live_vec;

        if (rd_en) begin
            if (addr == ADDR_W'(OFF_RECV)) begin
                st_d.rdata = live_any ? {rx_client, rx_signal} : RECV_EMPTY;
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign irq_o    = st_q.irq;
    assign pend_vec = st_q.pend;
    assign en_vec   = st_q.en;

endmodule

// File: rtl/ipsig_ctrl_chk.sv
module ipsig_ctrl_chk
    import ipsig_pkg::*;
#(
    parameter int NUM_CLIENTS = 8,
    parameter int NUM_SIGNALS = 4,
    parameter int ADDR_W      = 8,
    localparam int NUM_SLOTS  = NUM_CLIENTS * NUM_SIGNALS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          wdata,
    input logic [31:0]          rdata,
    input logic                 irq_o,
    input logic [NUM_SLOTS-1:0] pend_vec,
    input logic [NUM_SLOTS-1:0] en_vec
);

    logic recv_rd;
    logic other_rd;
    assign recv_rd  = rd_en && !wr_en && (addr == ADDR_W'(OFF_RECV));
    assign other_rd = rd_en && (addr != ADDR_W'(OFF_RECV));

    // Sentinel on a receive read coincides with a low interrupt
    assert_recv_matches_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recv_rd |=> ((rdata == RECV_EMPTY) == !irq_o));

    // A reported identifier always names a slot inside the table
    assert_recv_in_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
        recv_rd |=> (rdata == RECV_EMPTY) ||
                    ((rdata[31:16] < HALF_W'(NUM_CLIENTS)) &&
                     (rdata[15:0]  < HALF_W'(NUM_SIGNALS))));

    assert_other_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        other_rd |=> (rdata == '0));

    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // Arm/disarm writes leave pending state alone
    assert_arm_keeps_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((addr == ADDR_W'(OFF_ARM)) || (addr == ADDR_W'(OFF_DISARM))))
        |=> $stable(pend_vec));

    // Raise/ack writes leave enables alone
    assert_raise_keeps_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((addr == ADDR_W'(OFF_RAISE)) || (addr == ADDR_W'(OFF_ACK))))
        |=> $stable(en_vec));

    // Out-of-table identifier changes nothing
    assert_foreign_id_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wdata[31:16] >= HALF_W'(NUM_CLIENTS)) ||
                   (wdata[15:0]  >= HALF_W'(NUM_SIGNALS))))
        |=> ($stable(pend_vec) && $stable(en_vec)));

    assert_irq_follows_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend_vec & en_vec))));

endmodule

bind ipsig_ctrl ipsig_ctrl_chk #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .NUM_SIGNALS (NUM_SIGNALS),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq_o    (irq_o),
    .pend_vec (pend_vec),
    .en_vec   (en_vec)
);

// File: tb/ipsig_ctrl_tb.sv
module ipsig_ctrl_tb;

    localparam int NC     = 8;
    localparam int NS     = 4;
    localparam int ADDR_W = 8;
    localparam int NSLOT  = NC * NS;

    localparam logic [7:0] A_RAISE  = 8'h0C;
    localparam logic [7:0] A_RECV   = 8'h10;
    localparam logic [7:0] A_ARM    = 8'h14;
    localparam logic [7:0] A_DISARM = 8'h18;
    localparam logic [7:0] A_ACK    = 8'h1C;
    localparam logic [31:0] EMPTY   = 32'hFFFF_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq_o;

    int checks   = 0;
    int failures = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    // Reference table kept from the requirements
    logic [NSLOT-1:0] m_pend = '0;
    logic [NSLOT-1:0] m_en   = '0;

    always #2 clk = ~clk;   // 250 MHz

    ipsig_ctrl #(
        .NUM_CLIENTS (NC),
        .NUM_SIGNALS (NS),
        .ADDR_W      (ADDR_W)
    ) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_o (irq_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [31:0] id);
        if (id[31:16] < 16'(NC) && id[15:0] < 16'(NS))
            return int'(id[31:16]) * NS + int'(id[15:0]);
        return -1;
    endfunction

    function automatic logic [31:0] model_recv();
        for (int i = 0; i < NSLOT; i++)
            if (m_pend[i] && m_en[i]) return {16'(i / NS), 16'(i % NS)};
        return EMPTY;
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        int s;
        s = slot_of(d);
        if (s >= 0) begin
            case (a)
                A_RAISE:  m_pend[s] = 1'b1;
                A_ACK:    m_pend[s] = 1'b0;
                A_ARM:    m_en[s]   = 1'b1;
                A_DISARM: m_en[s]   = 1'b0;
                default:  ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: push the expected value, then strobe the read
    task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_recv(input string tag);
        do_read(A_RECV, model_recv(), tag);
    endtask

    // Interrupt lags the table by one register stage
    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        check({31'd0, irq_o}, {31'd0, exp}, tag);
    endtask

    always @(posedge clk) rd_seen <= rd_en && rst_n;

    // Monitor: compare read data the cycle after each strobe
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL scoreboard: actual=%h expected=none", rdata);
            end else begin
                check(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        check(rdata, 32'd0, "R1 rdata after reset");
        check({31'd0, irq_o}, 32'd0, "R1 irq after reset");
        rst_n = 1'b1;
        @(negedge clk);
        do_read(A_RECV, EMPTY, "R1 empty receive");

        // Pending but not enabled: invisible
        do_write(A_RAISE, 32'h0002_0001);
        read_recv("R3 disabled pending hidden");
        check_irq(1'b0, "R3 disabled no irq");

        // Enable it: now reported with packed layout
        do_write(A_ARM, 32'h0002_0001);
        do_read(A_RECV, 32'h0002_0001, "R2 packed id");
        check_irq(1'b1, "R8 irq high");

        // Lower slot wins
        do_write(A_RAISE, 32'h0000_0003);
        do_write(A_ARM,   32'h0000_0003);
        do_write(A_RAISE, 32'h0007_0003);
        do_write(A_ARM,   32'h0007_0003);
        do_read(A_RECV, 32'h0000_0003, "R5 lowest slot first");

        // Non-receive offsets read zero
        do_read(A_RAISE, 32'd0, "R9 read raise offset");
        do_read(A_ARM,   32'd0, "R9 read arm offset");
        do_read(8'h04,   32'd0, "R9 read unused offset");

        // Out-of-table identifiers ignored
        do_write(A_RAISE, 32'h0008_0000);
        do_write(A_ARM,   32'h0008_0000);
        do_write(A_RAISE, 32'h0000_0004);
        do_write(A_ARM,   32'h0000_0004);
        do_write(A_ACK,   32'h0100_0003);
        do_write(A_DISARM, 32'h0001_0003 | 32'h0010_0000);
        do_read(A_RECV, 32'h0000_0003, "R7 foreign ids ignored");

        // Disarm one slot: others keep enables, pending survives
        do_write(A_DISARM, 32'h0000_0003);
        do_read(A_RECV, 32'h0002_0001, "R4 disarm only named slot");
        do_write(A_ARM, 32'h0000_0003);
        do_read(A_RECV, 32'h0000_0003, "R10 pending survives disarm");

        // Drain loop
        for (int n = 0; n < 40; n++) begin
            v = model_recv();
            do_read(A_RECV, v, "R6 drain step");
            if (v == EMPTY) break;
            do_write(A_ACK, v);
        end
        check_irq(1'b0, "R8 irq low after drain");
        do_read(A_RECV, EMPTY, "R6 drained sentinel");

        // Clear of a disabled pending slot, then re-arm shows nothing
        do_write(A_RAISE, 32'h0005_0002);
        do_write(A_ACK,   32'h0005_0002);
        do_write(A_ARM,   32'h0005_0002);
        do_read(A_RECV, EMPTY, "R6 ack removes pending");
        check_irq(1'b0, "R8 irq stays low");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard: actual=%0d expected=0 leftover", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule